// File: doc/BRIEF.md
# Quad-Channel Serial Configuration Latch

This block holds the per-channel settings of a four-channel line codec. A host writes each channel through a three-wire serial port: a serial clock, a shared data line and one active-low select per channel. While a channel's select is low, each rising serial clock edge shifts one data bit into that channel's shift stage. When the select is released, a complete frame moves into the channel's holding latch. Only the latch drives the channel's standby, transmit gain, receive gain and balance network controls. A shared companding-law pin passes straight through to the codec.

All serial inputs are asynchronous to the system clock. They pass through synchronizers and are edge-detected in the system clock domain, so the serial clock must be several times slower than the system clock. While a channel is selected, its previously latched value is returned MSB first on a serial output that has a separate drive enable. This lets a host read the old setting while it writes the new one. The serial port is a fixed external protocol with no back-pressure: every accepted edge is consumed at once, and the block never stalls the host.

Top module: `quad_serial_ctl`

## Requirements
- R1: After reset every channel is in standby (`pwr_down` bit = 1). All transmit gain, receive gain and balance select bits are 0. The latched frame of every channel is 0x80.
- R2: A frame of exactly 8 bits is shifted MSB first and takes effect when the select is released. Frame bit 7 drives `pwr_down[i]`, where 1 means standby and 0 means active. Bits 4:3 drive `tx_gain[2i+1:2i]`, with bit 4 as the high bit. Bits 2:1 drive `rx_gain[2i+1:2i]`, with bit 2 as the high bit. Bit 0 drives `bal_sel[i]`, where 0 selects network 1 and 1 selects network 2. Bits 6:5 are reserved and change no output.
- R3: If a select period carries a number of serial clock rising edges other than 8 (fewer or more), the frame is discarded and the latch keeps its old value.
- R4: A channel whose select is high ignores the serial clock and data. Its outputs and latch stay unchanged while another channel is written.
- R5: A channel's outputs do not change while its select is low, including part-way through a frame.
- R6: `law_sel` follows `law_sel_in` combinationally. Value 1 selects A-law and value 0 selects µ-law.
- R7: While any select is low, `ser_dout_en` is 1. `ser_dout` first presents bit 7 of the selected channel's latch and moves to the next lower bit after each serial clock rising edge. With no select low, `ser_dout_en` and `ser_dout` are 0.
- R8: When several selects are low at once, every selected channel shifts the same data and commits it. Readback comes from the lowest-numbered selected channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous, sampled on its rising edge |
| sel_n | input | 4 | Per-channel active-low select |
| ser_din | input | 1 | Serial data in, MSB first |
| law_sel_in | input | 1 | Companding law select: 1 A-law, 0 µ-law |
| pwr_down | output | 4 | Per-channel standby: 1 standby, 0 active |
| tx_gain | output | 8 | Transmit gain code, 2 bits per channel |
| rx_gain | output | 8 | Receive gain code, 2 bits per channel |
| bal_sel | output | 4 | Balance network: 0 network 1, 1 network 2 |
| law_sel | output | 1 | Companding law select to the codec |
| ser_dout | output | 1 | Serial readback data |
| ser_dout_en | output | 1 | Drive enable for the readback pin |

## Verification
Full frames go to each channel in turn with codes that set every gain value, both balance choices and both standby states. One code sets only the reserved bits, which tells real field decode apart from a shifted or mis-sliced latch. Short and long frames separate an exact-count commit from commit-on-release. A frame that is stopped midway, with outputs sampled while the select is still low, separates a latched output from one taken from the shift stage. A two-channel broadcast exposes both the shared shifting and the readback priority. The readback captured during every write is compared against the previous value, which checks bit order and that the value returned is the latched one.

// File: rtl/qsc_pkg.sv
package qsc_pkg;
  localparam int FRAME_W = 8;
  localparam int POS_PDN = 7;
  localparam int POS_TX_HI = 4;
  localparam int POS_TX_LO = 3;
  localparam int POS_RX_HI = 2;
  localparam int POS_RX_LO = 1;
  localparam int POS_BAL = 0;
  localparam logic [FRAME_W-1:0] FRAME_RST = 8'h80;

  typedef struct packed {
    logic       pdn;
    logic [1:0] txg;
    logic [1:0] rxg;
    logic       bal;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);

  function automatic chan_cfg_t decode_frame(input logic [FRAME_W-1:0] f);
    chan_cfg_t c;
    c.pdn = f[POS_PDN];
    c.txg = {f[POS_TX_HI], f[POS_TX_LO]};
    c.rxg = {f[POS_RX_HI], f[POS_RX_LO]};
    c.bal = f[POS_BAL];
    return c;
  endfunction
endpackage

// File: rtl/qsc_sync.sv
module qsc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe   <= {STAGES{RST_VAL}};
      q_prev <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      q_prev <= pipe[STAGES-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/qsc_chan.sv
module qsc_chan
  import qsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_act,
  input  logic      sel_act_prev,
  input  logic      sclk_rise,
  input  logic      din,
  output chan_cfg_t cfg,
  output logic      rb_bit,
  output logic      frame_ok
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  logic [FRAME_W-1:0] shreg, latch_q, rb_q;
  logic [CNT_W-1:0]   cnt;
  logic               sel_start, sel_end, take;

  assign sel_start = sel_act & ~sel_act_prev;
  assign sel_end   = ~sel_act & sel_act_prev;
  assign take      = sel_act & ~sel_start & sclk_rise;
  assign frame_ok  = (cnt == CNT_W'(FRAME_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (sel_start) begin
      cnt <= '0;
    end else if (take) begin
      shreg <= {shreg[FRAME_W-2:0], din};
      if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= FRAME_RST;
    else if (sel_end && frame_ok) latch_q <= shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb_q <= '0;
    else if (sel_start) rb_q <= latch_q;
    else if (take) rb_q <= {rb_q[FRAME_W-2:0], 1'b0};
  end

  assign rb_bit = rb_q[FRAME_W-1];
  assign cfg    = decode_frame(latch_q);
endmodule

// File: rtl/quad_serial_ctl.sv
module quad_serial_ctl
  import qsc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic [NCH-1:0] sel_n,
  input  logic           ser_din,
  input  logic           law_sel_in,
  output logic [NCH-1:0] pwr_down,
  output logic [2*NCH-1:0] tx_gain,
  output logic [2*NCH-1:0] rx_gain,
  output logic [NCH-1:0] bal_sel,
  output logic           law_sel,
  output logic           ser_dout,
  output logic           ser_dout_en
);
  logic           sclk_q, sclk_prev, din_q, din_prev;
  logic [NCH-1:0] seln_q, seln_prev;
  logic [NCH-1:0] sel_act, sel_act_prev, rb_bits, frame_ok;
  logic           sclk_rise;
  logic [NCH-1:0][CFG_W-1:0] cfg_vec;

  qsc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sclk_q), .q_prev(sclk_prev));
  qsc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
    .clk(clk), .rst_n(rst_n), .d(ser_din), .q(din_q), .q_prev(din_prev));
  qsc_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL({NCH{1'b1}})) u_sync_sel (
    .clk(clk), .rst_n(rst_n), .d(sel_n), .q(seln_q), .q_prev(seln_prev));

  assign sclk_rise    = sclk_q & ~sclk_prev;
  assign sel_act      = ~seln_q;
  assign sel_act_prev = ~seln_prev;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_cfg_t c;
    qsc_chan u_ch (
      .clk(clk), .rst_n(rst_n), .sel_act(sel_act[i]), .sel_act_prev(sel_act_prev[i]),
      .sclk_rise(sclk_rise), .din(din_q), .cfg(c), .rb_bit(rb_bits[i]),
      .frame_ok(frame_ok[i]));
    assign cfg_vec[i]         = c;
    assign pwr_down[i]        = c.pdn;
    assign tx_gain[2*i +: 2]  = c.txg;
    assign rx_gain[2*i +: 2]  = c.rxg;
    assign bal_sel[i]         = c.bal;
  end

  always_comb begin
    ser_dout = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (sel_act[i]) ser_dout = rb_bits[i];
    end
  end

  assign ser_dout_en = |sel_act;
  assign law_sel     = law_sel_in;

  logic unused_din_prev;
  assign unused_din_prev = din_prev;
endmodule

// File: rtl/qsc_checker.sv
module qsc_checker #(
  parameter int NCH = 4,
  parameter int CW = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NCH-1:0]          sel_act,
  input logic                    sclk_rise,
  input logic [NCH-1:0]          frame_ok,
  input logic [NCH-1:0][CW-1:0]  cfg_vec,
  input logic [NCH-1:0]          pwr_down,
  input logic                    ser_dout,
  input logic                    ser_dout_en
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwr_down == '1));

  p_dout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_act == $past(sel_act) && $past(sel_act) == $past(sel_act, 2) && !$past(sclk_rise))
      |-> $stable(ser_dout));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_dout_en |-> !ser_dout);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_commit_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_vec[i]) |-> $past(!sel_act[i] && frame_ok[i]));

    p_hold_unsel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_act[i] && !$past(sel_act[i]) && !$past(sel_act[i], 2)) |-> $stable(cfg_vec[i]));

    p_hold_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_act[i] && $past(sel_act[i])) |-> $stable(cfg_vec[i]));
  end
endmodule

bind quad_serial_ctl qsc_checker #(.NCH(NCH), .CW(qsc_pkg::CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .sclk_rise(sclk_rise),
  .frame_ok(frame_ok), .cfg_vec(cfg_vec), .pwr_down(pwr_down),
  .ser_dout(ser_dout), .ser_dout_en(ser_dout_en));

// File: tb/sim_quad_serial_ctl.sv
`timescale 1ns/1ps
module sim_quad_serial_ctl;
  localparam int NCH = 4;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic [NCH-1:0] sel_n = '1;
  logic ser_din = 1'b0;
  logic law_sel_in = 1'b0;
  logic [NCH-1:0] pwr_down, bal_sel;
  logic [2*NCH-1:0] tx_gain, rx_gain;
  logic law_sel, ser_dout, ser_dout_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [NCH];

  always #2.5 clk = ~clk;

  quad_serial_ctl u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .sel_n(sel_n), .ser_din(ser_din),
    .law_sel_in(law_sel_in), .pwr_down(pwr_down), .tx_gain(tx_gain), .rx_gain(rx_gain),
    .bal_sel(bal_sel), .law_sel(law_sel), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en));

  // entry: channel(2) count(4) data(16)
  localparam logic [21:0] VEC [8] = '{
    {2'd0, 4'd8, 16'h0000}, {2'd1, 4'd8, 16'h001F}, {2'd2, 4'd8, 16'h00E5},
    {2'd3, 4'd8, 16'h004A}, {2'd0, 4'd5, 16'h0015}, {2'd1, 4'd9, 16'h01AA},
    {2'd2, 4'd8, 16'h0060}, {2'd0, 4'd8, 16'h0097}};

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(input string req);
    logic [NCH-1:0] epd, ebal;
    logic [2*NCH-1:0] etx, erx;
    for (int i = 0; i < NCH; i++) begin
      epd[i] = model[i][7];
      etx[2*i +: 2] = model[i][4:3];
      erx[2*i +: 2] = model[i][2:1];
      ebal[i] = model[i][0];
    end
    chk(req, {8'h0, pwr_down, bal_sel, tx_gain, rx_gain}, {8'h0, epd, ebal, etx, erx});
  endtask

  task automatic sel_begin(input logic [NCH-1:0] mask);
    sel_n = ~mask;
    wait_clk(HALF);
  endtask

  task automatic send_bit(input logic b, output logic rb);
    ser_din = b;
    wait_clk(HALF);
    rb = ser_dout;
    ser_clk = 1'b1;
    wait_clk(HALF);
    ser_clk = 1'b0;
  endtask

  task automatic sel_finish();
    wait_clk(HALF);
    sel_n = '1;
    wait_clk(2 * HALF);
  endtask

  task automatic write_frame(input logic [NCH-1:0] mask, input logic [15:0] bits,
                             input int n, output logic [7:0] rb);
    logic r;
    rb = '0;
    sel_begin(mask);
    for (int k = n - 1; k >= 0; k--) begin
      send_bit(bits[k], r);
      if (k >= n - 8) rb[7 - (n - 1 - k)] = r;
    end
    sel_finish();
  endtask

  initial begin
    wait_clk(100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    logic r;
    for (int i = 0; i < NCH; i++) model[i] = 8'h80;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    chk_outputs("R1 reset state");
    chk("R7 idle readback", {ser_dout_en, ser_dout}, 2'b00);

    // table walk: R2 decode, R3 discard, R4 other channels, R7 readback
    for (int v = 0; v < 8; v++) begin
      logic [1:0] ch;
      logic [3:0] n;
      logic [15:0] d;
      logic [7:0] prev;
      {ch, n, d} = VEC[v];
      prev = model[ch];
      write_frame(NCH'(1) << ch, d, int'(n), rb);
      if (n >= 8) chk($sformatf("R7 readback vec %0d", v), rb, prev);
      if (n == 8) model[ch] = d[7:0];
      chk_outputs($sformatf("R2 R3 R4 vec %0d", v));
    end

    // R6 law pass-through
    law_sel_in = 1'b1;
    #1 chk("R6 law A", law_sel, 1'b1);
    law_sel_in = 1'b0;
    #1 chk("R6 law mu", law_sel, 1'b0);

    // R5 outputs held mid-frame; readback enabled while selected
    sel_begin(4'b1000);
    chk("R7 dout_en while selected", ser_dout_en, 1'b1);
    for (int k = 7; k >= 4; k--) send_bit(1'b1, r);
    wait_clk(HALF);
    chk_outputs("R5 mid-frame hold");
    for (int k = 3; k >= 0; k--) send_bit(1'b1, r);
    wait_clk(HALF);
    chk_outputs("R5 full frame before release");
    sel_finish();
    model[3] = 8'hFF;
    chk_outputs("R2 commit all ones");

    // R8 broadcast to channels 1 and 2, readback from channel 1
    write_frame(4'b0110, 16'h0019, 8, rb);
    chk("R8 readback lowest channel", rb, model[1]);
    model[1] = 8'h19;
    model[2] = 8'h19;
    chk_outputs("R8 broadcast commit");

    // R3 zero-length select
    sel_begin(4'b0001);
    sel_finish();
    chk_outputs("R3 empty select");

    // R1 reset again
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    for (int i = 0; i < NCH; i++) model[i] = 8'h80;
    chk_outputs("R1 re-reset");
    write_frame(4'b0100, 16'h0000, 8, rb);
    chk("R1 reset latch readback", rb, 8'h80);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule